// File: doc/BRIEF.md
# Register-Gated Bit-Bang Serial DAC Port

This block is a small bus-attached register file. A host uses it to load a daisy chain of serial DACs one bit at a time, with one bus write per bit. The host first sets a programming-enable bit. It then pulls the chain's chip-select low through a second control register. It then writes the data register once for each serial bit. On each such write the block places bit 0 of the write data on the serial data line. After a settle delay it fires one positive serial clock pulse of fixed width, with no further help from the host. To make the chain act on the shifted bits, the host raises chip-select again.

While the enable bit is clear, the DACs are protected: chip-select is forced inactive and the serial clock is held low. The serial output that returns from the last device in the chain passes through a two-flop synchronizer and can be read in a status register, so the host can test the chain. A separate control bit drives an ADC power-enable output. That bit comes out of reset cleared.

Top module: `dac_bitbang_port`

## Requirements
- R1: After reset, control register 1 (address 0) reads 0x0000 and control register 2 (address 1) reads 0x0040. `dac_cs_n` is 1, and `dac_sclk`, `dac_sdi`, `adc_en` and `busy` are all 0.
- R2: Control registers 1 and 2 store all 16 written bits. A read strobe to either register returns the stored value on `bus_rdata` in the cycle after the strobe, and `bus_rdata` holds that value until the next read.
- R3: `adc_en` equals bit 7 of control register 1.
- R4: While bit 5 of control register 1 (programming enable) is 0, `dac_cs_n` is 1 and `dac_sclk` is 0, whatever the other register bits hold.
- R5: While programming is enabled, `dac_cs_n` equals bit 6 of control register 2.
- R6: A write to address 4 while programming is enabled and `busy` is 0 sets `dac_sdi` to bit 0 of the write data from the next cycle on. Counting the write edge as edge 0, `dac_sclk` rises at edge SETTLE_CYC, stays high for HIGH_CYC cycles, and then returns low.
- R7: `busy` is 1 from the accepted data write until the pulse ends. A data write that arrives while `busy` is 1 changes neither `dac_sdi` nor the clock pulse.
- R8: A data write while programming is disabled has no effect: `dac_sdi` keeps its value, and `busy` and `dac_sclk` stay 0.
- R9: A read of address 3 returns the level of `dac_sdo` sampled through two flops, in bit 4, with all other bits 0. Writes to address 3 change no register. Reads of address 4 and of unused addresses return 0.
- R10: Clearing programming enable during a pulse drives `dac_sclk` low in the cycle right after the write, and `busy` is 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_rdata | output | 16 | Read data, valid the cycle after the read strobe |
| dac_cs_n | output | 1 | Chip-select to the chain, active low |
| dac_sclk | output | 1 | Serial clock to the chain |
| dac_sdi | output | 1 | Serial data into the first device |
| dac_sdo | input | 1 | Serial data returning from the last device |
| adc_en | output | 1 | ADC power enable |
| busy | output | 1 | A clock pulse is in progress |

## Verification
The bench shifts two full 32-bit chain words through the port, one bit at a time. For every bit it checks the exact cycle in which the clock rises and the cycle in which it falls, so an off-by-one settle or high counter shows up at once. It then sends a data write while `busy` is high and another while programming is disabled. A design that queued or accepted either write would change `dac_sdi` or emit an extra clock edge. Finally it clears the enable bit in the middle of a pulse, where a design that gated the clock late would leave `dac_sclk` high for one cycle too many. It also sweeps all four combinations of enable and chip-select, and both levels of the returning serial line.

// File: rtl/dbb_pkg.sv
package dbb_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_CTRL1 = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL2 = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd4;

  localparam int EN_BIT  = 5;
  localparam int ADC_BIT = 7;
  localparam int CS_BIT  = 6;
  localparam int SDO_BIT = 4;

  localparam logic [DATA_W-1:0] CTRL1_RST = 16'h0000;
  localparam logic [DATA_W-1:0] CTRL2_RST = 16'h0040;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_HIGH   = 2'd2
  } pulse_phase_t;
endpackage

// File: rtl/dbb_sync.sv
module dbb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_in};
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/dbb_regs.sv
module dbb_regs
  import dbb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  input  logic              sdo_sync,
  output logic [DATA_W-1:0] ctrl1_q,
  output logic [DATA_W-1:0] ctrl2_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              data_wr
);
  logic [DATA_W-1:0] status_w;
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl1_q <= CTRL1_RST;
      ctrl2_q <= CTRL2_RST;
    end else if (wr) begin
      if (addr == A_CTRL1) ctrl1_q <= wdata;
      if (addr == A_CTRL2) ctrl2_q <= wdata;
    end
  end

  always_comb begin
    status_w          = '0;
    status_w[SDO_BIT] = sdo_sync;
  end

  always_comb begin
    case (addr)
      A_CTRL1: rd_mux = ctrl1_q;
      A_CTRL2: rd_mux = ctrl2_q;
      A_STAT:  rd_mux = status_w;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign data_wr = wr && (addr == A_DATA);
endmodule

// File: rtl/dbb_pulse.sv
module dbb_pulse
  import dbb_pkg::*;
#(
  parameter int SETTLE_CYC = 2,
  parameter int HIGH_CYC   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic start,
  input  logic bit_in,
  output logic sdi_q,
  output logic sclk_raw,
  output logic busy
);
  localparam int MAXC = (SETTLE_CYC > HIGH_CYC) ? SETTLE_CYC : HIGH_CYC;
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] HIGH_LAST   = CW'(HIGH_CYC - 1);

  pulse_phase_t phase_q;
  logic [CW-1:0] cnt_q;
  logic accept;

  assign accept = start && enable && (phase_q == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sdi_q   <= 1'b0;
    end else if (!enable) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            sdi_q   <= bit_in;
            phase_q <= PH_SETTLE;
            cnt_q   <= '0;
          end
        end
        PH_SETTLE: begin
          if (cnt_q == SETTLE_LAST) begin
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt_q == HIGH_LAST) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign sclk_raw = (phase_q == PH_HIGH);
  assign busy     = (phase_q != PH_IDLE);
endmodule

// File: rtl/dac_bitbang_port.sv
module dac_bitbang_port
  import dbb_pkg::*;
#(
  parameter int SETTLE_CYC  = 2,
  parameter int HIGH_CYC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              dac_cs_n,
  output logic              dac_sclk,
  output logic              dac_sdi,
  input  logic              dac_sdo,
  output logic              adc_en,
  output logic              busy
);
  logic [DATA_W-1:0] ctrl1_q;
  logic [DATA_W-1:0] ctrl2_q;
  logic sdo_sync;
  logic data_wr;
  logic sclk_raw;
  logic prog_en;

  dbb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (dac_sdo),
    .d_out (sdo_sync)
  );

  dbb_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .sdo_sync (sdo_sync),
    .ctrl1_q  (ctrl1_q),
    .ctrl2_q  (ctrl2_q),
    .rdata_q  (bus_rdata),
    .data_wr  (data_wr)
  );

  assign prog_en = ctrl1_q[EN_BIT];

  dbb_pulse #(.SETTLE_CYC(SETTLE_CYC), .HIGH_CYC(HIGH_CYC)) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .enable   (prog_en),
    .start    (data_wr),
    .bit_in   (bus_wdata[0]),
    .sdi_q    (dac_sdi),
    .sclk_raw (sclk_raw),
    .busy     (busy)
  );

  assign dac_cs_n = !prog_en || ctrl2_q[CS_BIT];
  assign dac_sclk = prog_en && sclk_raw;
  assign adc_en   = ctrl1_q[ADC_BIT];
endmodule

// File: rtl/dbb_chk.sv
module dbb_chk
  import dbb_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] ctrl1_q,
  input logic              dac_cs_n,
  input logic              dac_sclk,
  input logic              dac_sdi,
  input logic              busy
);
  logic en;
  assign en = ctrl1_q[EN_BIT];

  // R4
  prot_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !en |-> (dac_cs_n && !dac_sclk));

  // R6
  sclk_busy_chk: assert property (@(posedge clk) disable iff (rst)
    dac_sclk |-> busy);

  // R6
  sdi_settled_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_sclk) |-> $stable(dac_sdi));

  // R7
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_wr && bus_addr == A_DATA) |=> $stable(dac_sdi));

  // R8
  disabled_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && bus_wr && bus_addr == A_DATA) |=> ($stable(dac_sdi) && !busy));
endmodule

bind dac_bitbang_port dbb_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .ctrl1_q  (ctrl1_q),
  .dac_cs_n (dac_cs_n),
  .dac_sclk (dac_sclk),
  .dac_sdi  (dac_sdi),
  .busy     (busy)
);

// File: tb/dac_bitbang_port_bench.sv
module dac_bitbang_port_bench;
  localparam int S = 2;
  localparam int H = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic dac_cs_n, dac_sclk, dac_sdi, dac_sdo, adc_en, busy;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  dac_bitbang_port #(.SETTLE_CYC(S), .HIGH_CYC(H), .SYNC_STAGES(2)) u_dac_bitbang_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdi(dac_sdi),
    .dac_sdo(dac_sdo), .adc_en(adc_en), .busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  // after an accepted data write: walk the pulse cycle by cycle (R6, R7)
  task automatic pulse_chk(input logic b);
    for (int k = 0; k <= S + H; k++) begin
      if (k == 0) check("R6 sdi", 32'(dac_sdi), 32'(b));
      check("R6 sclk", 32'(dac_sclk), 32'((k >= S) && (k < S + H)));
      check("R7 busy", 32'(busy), 32'(k < S + H));
      if (k < S + H) @(negedge clk);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] v;
    logic [31:0] word;
    int edges;
    dac_sdo = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 cs_n", 32'(dac_cs_n), 1);
    check("R1 sclk", 32'(dac_sclk), 0);
    check("R1 sdi", 32'(dac_sdi), 0);
    check("R1 adc_en", 32'(adc_en), 0);
    check("R1 busy", 32'(busy), 0);
    rd(3'd0, v); check("R1 ctrl1", 32'(v), 32'h0000);
    rd(3'd1, v); check("R1 ctrl2", 32'(v), 32'h0040);

    // R2, R3 register sweep
    for (int i = 0; i < 8; i++) begin
      logic [15:0] p;
      p = 16'(16'h1357 * (i + 1)) ^ 16'(i << 7);
      wr(3'd1, p);
      rd(3'd1, v); check("R2 ctrl2", 32'(v), 32'(p));
      @(negedge clk);
      check("R2 hold", 32'(bus_rdata), 32'(p));
      wr(3'd0, p & 16'hFFDF);
      rd(3'd0, v); check("R2 ctrl1", 32'(v), 32'(p & 16'hFFDF));
      check("R3 adc_en", 32'(adc_en), 32'(p[7]));
    end

    // R4, R5 enable x chip-select sweep
    for (int e = 0; e < 2; e++)
      for (int c = 0; c < 2; c++) begin
        wr(3'd0, 16'((e << 5) | 16'h0F1F));
        wr(3'd1, 16'((c << 6) | 16'hA800));
        if (e == 0) check("R4 cs_n", 32'(dac_cs_n), 1);
        else        check("R5 cs_n", 32'(dac_cs_n), 32'(c));
        check("R4 sclk", 32'(dac_sclk), 0);
      end

    // R8 disabled data write
    wr(3'd0, 16'h0000);
    wr(3'd4, 16'h0001);
    for (int k = 0; k < 6; k++) begin
      check("R8 sdi", 32'(dac_sdi), 0);
      check("R8 sclk", 32'(dac_sclk), 0);
      check("R8 busy", 32'(busy), 0);
      @(negedge clk);
    end

    // R6 shift two chain words bit by bit, MSB first
    wr(3'd0, 16'h0020);
    wr(3'd1, 16'h0000);
    check("R5 cs low", 32'(dac_cs_n), 0);
    for (int w = 0; w < 2; w++) begin
      word = (w == 0) ? {8'h00, 4'h3, 4'h2, 12'hE67, 4'h0}
                      : {8'hFF, 4'hF, 4'hF, 12'h5A3, 4'hC};
      for (int i = 31; i >= 0; i--) begin
        wr(3'd4, {15'h7FF5, word[i]});
        pulse_chk(word[i]);
      end
    end
    wr(3'd1, 16'h0040);
    check("R5 cs high", 32'(dac_cs_n), 1);

    // R7 write while busy is dropped
    wr(3'd4, 16'h0000);
    edges = 0;
    wr(3'd4, 16'h0001);
    for (int k = 1; k <= S + H + 2; k++) begin
      if (dac_sclk) edges++;
      check("R7 sdi held", 32'(dac_sdi), 0);
      @(negedge clk);
    end
    check("R7 high cycles", 32'(edges), 32'(H));
    wr(3'd4, 16'h0001);
    pulse_chk(1'b1);

    // R10 disable mid-pulse
    wr(3'd4, 16'h0000);
    repeat (S) @(negedge clk);
    check("R10 sclk up", 32'(dac_sclk), 1);
    wr(3'd0, 16'h0000);
    check("R10 sclk", 32'(dac_sclk), 0);
    @(negedge clk);
    check("R10 busy", 32'(busy), 0);

    // R9 status, read-only, write-only, unused
    for (int s = 0; s < 2; s++) begin
      dac_sdo = s[0];
      repeat (3) @(negedge clk);
      rd(3'd3, v); check("R9 status", 32'(v), 32'(s << 4));
    end
    wr(3'd0, 16'h1234);
    wr(3'd1, 16'h4321);
    wr(3'd3, 16'hFFFF);
    rd(3'd0, v); check("R9 ctrl1 kept", 32'(v), 32'h1234);
    rd(3'd1, v); check("R9 ctrl2 kept", 32'(v), 32'h4321);
    rd(3'd4, v); check("R9 data rd", 32'(v), 0);
    rd(3'd2, v); check("R9 unused", 32'(v), 0);
    rd(3'd7, v); check("R9 unused", 32'(v), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule